// File: doc/BRIEF.md
# Synchronous FIFO with Status Flags

This block is a single-clock first-in first-out buffer with a configurable data width and depth. A producer offers a word by raising the write request. A consumer pulls the oldest stored word by raising the read request, and that word appears on the read-data output one clock later. A single occupancy counter drives every level indicator: full, almost full, empty and almost empty. Three registered one-cycle pulses report how each request ended: a write acknowledge, an overflow error and an underflow error.

Requests are qualified against the occupancy the FIFO had in the cycle they arrive, and the rule is fixed at both boundaries. A write while full is dropped and a read while empty is dropped. If both requests arrive while full, only the read is served. If both arrive while empty, only the write is served. Anywhere between the boundaries, both are served together. The reset is asynchronous and active low. It clears the storage array, both pointers, the counter, the read-data register and every flag.

Top module: `sfifo_flagged`

## Requirements
- R1: While `rst_n` is low, without waiting for a clock edge, `empty` is 1, and `full`, `almost_full`, `almost_empty`, `wr_ack`, `overflow`, `underflow` and `rd_data` are all 0. After release the FIFO behaves as empty.
- R2: A write request made while not full stores `wr_data`, and `wr_ack` is 1 during the next clock cycle only. `wr_ack` is 0 in every other cycle.
- R3: A write request made while full leaves the stored contents unchanged, and `overflow` is 1 during the next clock cycle only. `overflow` is 0 in every other cycle.
- R4: A read request made while empty is ignored, leaves `rd_data` unchanged, and makes `underflow` 1 during the next clock cycle only. `underflow` is 0 in every other cycle.
- R5: An accepted read places the oldest stored word on `rd_data` at the next clock edge. `rd_data` keeps its value in every cycle without an accepted read.
- R6: `full` is 1 exactly when the occupancy equals DEPTH, and `empty` is 1 exactly when the occupancy is 0.
- R7: `almost_full` is 1 exactly when the occupancy equals DEPTH-1.
- R8: `almost_empty` is 1 exactly when the occupancy equals 1.
- R9: Simultaneous write and read requests while full perform only the read. The occupancy drops by one and `overflow` pulses.
- R10: Simultaneous write and read requests while empty perform only the write. The occupancy rises by one and `underflow` pulses.
- R11: Simultaneous write and read requests while neither full nor empty perform both, and the occupancy is unchanged.
- R12: Both pointers wrap modulo DEPTH, so words keep their order under sustained traffic of more than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| full | output | 1 | Occupancy equals DEPTH |
| almost_full | output | 1 | Occupancy equals DEPTH-1 |
| empty | output | 1 | Occupancy equals 0 |
| almost_empty | output | 1 | Occupancy equals 1 |
| wr_ack | output | 1 | One-cycle pulse after an accepted write |
| overflow | output | 1 | One-cycle pulse after a write attempted while full |
| underflow | output | 1 | One-cycle pulse after a read attempted while empty |

## Verification
A queue-based model in the bench predicts every output on every cycle. The stimulus runs through these patterns in turn: read-only requests on an empty FIFO, write-only filling to full, repeated writes into a full FIFO, draining past empty, and both requests together at empty, at full and at middle occupancy. The paired-request cases separate the three arbitration rules, since each boundary serves a different request and produces a different error pulse. A long mixed stream of uneven write and read rates carries words across several pointer wraps, and any slip in wrap or ordering shows up as wrong read data. A reset asserted in the middle of a cycle confirms that the outputs clear before any clock edge.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Occupancy class seen by the arbitration logic
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_t;

    // Transfers actually performed in a cycle
    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;

    // Outcome pulses registered for the next cycle
    typedef struct packed {
        logic ack;
        logic ovf;
        logic udf;
    } evt_t;

    // Boundary arbitration: a full FIFO refuses the write, an empty FIFO refuses the read
    function automatic xfer_t arbitrate(input logic wr, input logic rd, input occ_t occ);
        xfer_t x;
        x.push = wr && (occ != OCC_FULL);
        x.pop  = rd && (occ != OCC_EMPTY);
        return x;
    endfunction

    function automatic evt_t classify(input logic wr, input logic rd, input occ_t occ);
        evt_t e;
        e.ack = wr && (occ != OCC_FULL);
        e.ovf = wr && (occ == OCC_FULL);
        e.udf = rd && (occ == OCC_EMPTY);
        return e;
    endfunction

endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            if (ptr == LAST) begin
                ptr <= '0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfifo_occupancy.sv
module sfifo_occupancy
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  xfer_t xfer,
    output occ_t  occ,
    output logic  full,
    output logic  almost_full,
    output logic  empty,
    output logic  almost_empty
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({xfer.push, xfer.pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        full         = (count == CNT_FULL);
        empty        = (count == '0);
        almost_full  = (count == CNT_HIGH);
        almost_empty = (count == CNT_ONE);
        if (full) begin
            occ = OCC_FULL;
        end else if (empty) begin
            occ = OCC_EMPTY;
        end else begin
            occ = OCC_PART;
        end
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (pop) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/sfifo_events.sv
module sfifo_events
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt_d,
    output evt_t evt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end
endmodule

// File: rtl/sfifo_flagged.sv
module sfifo_flagged
    import sfifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              almost_full,
    output logic              empty,
    output logic              almost_empty,
    output logic              wr_ack,
    output logic              overflow,
    output logic              underflow
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = ADDR_W + 1;

    occ_t  occ;
    xfer_t xfer;
    evt_t  evt_d;
    evt_t  evt_q;
    logic [ADDR_W-1:0] ptrs [2];
    logic [1:0]        adv;

    always_comb begin
        xfer  = arbitrate(wr_en, rd_en, occ);
        evt_d = classify(wr_en, rd_en, occ);
        adv   = {xfer.pop, xfer.push};
    end

    // index 0 is the write pointer, index 1 the read pointer
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        sfifo_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[g]),
            .ptr   (ptrs[g])
        );
    end

    sfifo_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer         (xfer),
        .occ          (occ),
        .full         (full),
        .almost_full  (almost_full),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (xfer.push),
        .waddr (ptrs[0]),
        .wdata (wr_data),
        .pop   (xfer.pop),
        .raddr (ptrs[1]),
        .rdata (rd_data)
    );

    sfifo_events i_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_d (evt_d),
        .evt_q (evt_q)
    );

    assign wr_ack    = evt_q.ack;
    assign overflow  = evt_q.ovf;
    assign underflow = evt_q.udf;
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              almost_full,
    input logic              empty,
    input logic              almost_empty,
    input logic              wr_ack,
    input logic              overflow,
    input logic              underflow
);
    assert_ack_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> (wr_ack && !overflow));

    assert_overflow_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (overflow && !wr_ack));

    assert_underflow_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> underflow);

    assert_rd_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !empty) |=> $stable(rd_data));

    assert_full_empty_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_full_pair_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> (!full && almost_full));

    assert_empty_pair_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_en && rd_en) |=> (!empty && almost_empty));

    assert_mid_pair_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !full && !empty) |=>
        ($stable(full) && $stable(empty) && $stable(almost_full) && $stable(almost_empty)));
endmodule

bind sfifo_flagged sfifo_checker #(.DATA_W(DATA_W)) i_sfifo_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .full         (full),
    .almost_full  (almost_full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .wr_ack       (wr_ack),
    .overflow     (overflow),
    .underflow    (underflow)
);

// File: tb/test_sfifo_flagged.sv
`timescale 1ns/1ps
module test_sfifo_flagged;
    localparam int DW    = 8;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic full, almost_full, empty, almost_empty, wr_ack, overflow, underflow;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [DW-1:0] mq [$];
    logic [DW-1:0] e_rd = '0;
    bit e_ack = 1'b0, e_ovf = 1'b0, e_udf = 1'b0;

    always #2.5 clk = ~clk;

    sfifo_flagged #(.DATA_W(DW), .DEPTH(DEPTH)) i_sfifo_flagged (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .full         (full),
        .almost_full  (almost_full),
        .empty        (empty),
        .almost_empty (almost_empty),
        .wr_ack       (wr_ack),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    task automatic chk(input string req, input string scen, input string what,
                       input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s (%s) %s: got %0d expected %0d", req, scen, what, got, exp);
        end
    endtask

    task automatic check_all(input string scen);
        int sz;
        sz = mq.size();
        chk("R6", scen, "full",         int'(full),         int'(sz == DEPTH));
        chk("R6", scen, "empty",        int'(empty),        int'(sz == 0));
        chk("R7", scen, "almost_full",  int'(almost_full),  int'(sz == DEPTH - 1));
        chk("R8", scen, "almost_empty", int'(almost_empty), int'(sz == 1));
        chk("R2", scen, "wr_ack",       int'(wr_ack),       int'(e_ack));
        chk("R3", scen, "overflow",     int'(overflow),     int'(e_ovf));
        chk("R4", scen, "underflow",    int'(underflow),    int'(e_udf));
        chk("R5", scen, "rd_data",      int'(rd_data),      int'(e_rd));
    endtask

    // called just after a falling edge; results are sampled at the next falling edge
    task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input string scen);
        int sz;
        sz = mq.size();
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        e_ack = w && (sz != DEPTH);
        e_ovf = w && (sz == DEPTH);
        e_udf = r && (sz == 0);
        if (r && sz != 0) e_rd = mq.pop_front();
        if (w && sz != DEPTH) mq.push_back(d);
        @(negedge clk);
        check_all(scen);
    endtask

    task automatic reset_checks(input string scen);
        chk("R1", scen, "empty",        int'(empty),        1);
        chk("R1", scen, "full",         int'(full),         0);
        chk("R1", scen, "almost_full",  int'(almost_full),  0);
        chk("R1", scen, "almost_empty", int'(almost_empty), 0);
        chk("R1", scen, "wr_ack",       int'(wr_ack),       0);
        chk("R1", scen, "overflow",     int'(overflow),     0);
        chk("R1", scen, "underflow",    int'(underflow),    0);
        chk("R1", scen, "rd_data",      int'(rd_data),      0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        reset_checks("power-on reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 idle after release");

        // reads on an empty FIFO
        cyc(1'b0, '0, 1'b1, "R4 read empty");
        cyc(1'b0, '0, 1'b1, "R4 read empty again");
        // both requests while empty
        cyc(1'b1, 8'hA0, 1'b1, "R10 pair at empty");
        cyc(1'b0, '0, 1'b1, "R5 read single");
        cyc(1'b0, '0, 1'b0, "R5 idle hold");

        // fill to full
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, DW'(8'h40 + i), 1'b0, "R2 fill");
        cyc(1'b1, 8'hEE, 1'b0, "R3 write full");
        cyc(1'b1, 8'hEF, 1'b0, "R3 write full again");
        // both requests while full
        cyc(1'b1, 8'hDD, 1'b1, "R9 pair at full");
        // both requests in the middle
        cyc(1'b1, 8'h77, 1'b1, "R11 pair mid");
        cyc(1'b1, 8'h78, 1'b1, "R11 pair mid");
        cyc(1'b1, 8'h79, 1'b1, "R11 pair mid");
        // drain past empty
        for (int i = 0; i < DEPTH + 1; i++) cyc(1'b0, '0, 1'b1, "R5 drain");

        // uneven stream across several wraps
        for (int i = 0; i < 6 * DEPTH; i++)
            cyc((i % 3) != 2, DW'(i * 7 + 3), (i % 4) == 1 || (i % 4) == 3, "R12 stream");
        for (int i = 0; i < 3 * DEPTH; i++)
            cyc((i % 5) != 0, DW'(i * 11 + 1), (i % 3) != 0, "R12 stream b");

        // mid-cycle asynchronous reset with data held
        cyc(1'b0, '0, 1'b0, "R1 settle");
        cyc(1'b1, 8'h5A, 1'b0, "R1 pre-reset write");
        wr_en = 1'b0;
        rd_en = 1'b0;
        #1 rst_n = 1'b0;
        #0.5;
        reset_checks("async reset before edge");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        e_rd = '0; e_ack = 1'b0; e_ovf = 1'b0; e_udf = 1'b0;
        @(negedge clk);
        check_all("R1 after mid reset");
        cyc(1'b0, '0, 1'b1, "R1 read after reset");
        cyc(1'b1, 8'h33, 1'b0, "R1 write after reset");
        cyc(1'b0, '0, 1'b1, "R1 read back after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule